// File: doc/BRIEF.md
# Shift Unit with Condition Codes

This block executes the shift group of a two-operand CISC integer core. It covers logical and arithmetic shifts, left and right, on 8-bit, 16-bit and 32-bit data-register operands, plus a single-step shift of a 16-bit memory word. The shift count comes from one of three places. It can be a 3-bit immediate field in the opcode, where a field value of zero means eight. It can be the low six bits of a count register, which makes it modulo 64 for every operand size. In the memory form it is always one.

The unit returns the destination value with the shifted operand merged into its low byte, low word or whole long, and it returns the five condition flags. Inputs are latched on a valid/ready handshake, and the outputs appear in the following cycle. A mode input selects between two overflow rules. In full mode, overflow is set if the sign bit changed at any point during an arithmetic left shift. In reduced mode, overflow is always cleared.

Top module: `shift_cc_unit`

## Requirements
- R1: A request accepted while `in_valid_i` and `in_ready_o` are both high sets `out_valid_o` in the next cycle. While `out_valid_o` is high and `out_ready_i` is low, the outputs hold steady. `in_ready_o` is high whenever the output stage is empty or being drained.
- R2: The opcode fields decode as follows. Bit 8 set means left and clear means right. Bit 3 set means logical and clear means arithmetic. Bits 7..6 give the size: 00 for byte, 01 for word, 10 for long and 11 for the memory word. For the three register sizes, bit 5 set selects the count register and bit 5 clear selects the immediate count.
- R3: The count is opcode bits 11..9 in the immediate form, with 0 meaning 8. In the register form it is `cnt_reg_i[5:0]`. In the memory-word form it is 1.
- R4: The result is computed as follows. A left shift fills with zeros. A logical right shift fills with zeros. An arithmetic right shift fills with copies of the operand's sign bit. A count at or above the operand width gives zero, or gives all sign bits for an arithmetic right shift.
- R5: For byte, word and memory-word operands, the bits of `dst_i` above the operand width pass unchanged to `result_o`.
- R6: C (`flags_o[0]`) is the last bit shifted out. It is 0 for a count of 0. Past the operand width it is 0, except for an arithmetic right shift, where it is the operand's sign bit.
- R7: X (`flags_o[4]`) is set equal to C when the count is non-zero. When the count is zero, X keeps `x_i`.
- R8: N (`flags_o[3]`) is the top bit of the result at the operand width. Z (`flags_o[2]`) is set when the result at the operand width is zero.
- R9: V (`flags_o[1]`) is 0 for logical shifts, for right shifts, and whenever `ovf_full_i` is 0.
- R10: When `ovf_full_i` is 1, V for an arithmetic left shift is 1 exactly when the operand's top bit takes a value different from its original sign at any step of the shift. Zeros shifting in past the width count as such steps.
- R11: The memory-word form shifts 16 bits by one. For an arithmetic left shift in full mode, its V is the XOR of the old and new bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request can be accepted |
| opcode_i | input | 16 | Shift-group opcode word |
| dst_i | input | 32 | Destination register or memory word (low 16 bits) |
| cnt_reg_i | input | 32 | Count register value |
| x_i | input | 1 | Current extend flag |
| ovf_full_i | input | 1 | 1: sign-change overflow rule, 0: overflow always cleared |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 32 | Merged destination value |
| flags_o | output | 5 | {X, N, Z, V, C} |

## Verification
The bench sweeps the following configurations:
- every size, direction and kind of shift;
- immediate fields 0 to 7 and every count register value from 0 to 63;
- both overflow modes;
- eight operand patterns.

The operand patterns are chosen to separate cases that a partial design would merge. These are zero, all ones, an isolated top bit, an isolated low bit, and mixed patterns whose byte, word and long signs differ.

The sweep separates several behaviours:
- Counts past the width separate the zero fill from the sign fill and test the carry beyond the edge.
- Count zero separates the held extend flag from the copied carry.
- Operands with upper bytes that differ from the lane catch merge errors.
- Positive operands with high interior bits catch an overflow rule that compares only the start and end sign.

A stalled-output case checks that results are held.

// File: rtl/shift_cc_pkg.sv
package shift_cc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned EXT_W  = 2 * DATA_W;
  localparam int unsigned CNT_W  = $clog2(EXT_W);
  localparam int unsigned FLAG_W = 5;
  localparam int unsigned LANES  = $clog2(DATA_W / 8) + 1;
  localparam int unsigned OVF_CAP = DATA_W;

  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_V = 1;
  localparam int unsigned FLG_Z = 2;
  localparam int unsigned FLG_N = 3;
  localparam int unsigned FLG_X = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_MEMW = 2'b11
  } size_e;

  typedef struct packed {
    logic             left;
    logic             logical;
    size_e            size;
    logic [CNT_W-1:0] cnt;
  } shift_op_t;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_cc_pkg::*;
(
  input  logic [15:0]      opcode_i,
  input  logic [CNT_W-1:0] cnt_reg_i,
  output shift_op_t        op_o
);
  localparam int unsigned IMM_W = 3;

  logic [IMM_W-1:0] imm;
  assign imm = opcode_i[11:9];

  always_comb begin
    op_o.left    = opcode_i[8];
    op_o.logical = opcode_i[3];
    op_o.size    = size_e'(opcode_i[7:6]);
    if (op_o.size == SZ_MEMW) begin
      op_o.cnt = CNT_W'(1);
    end else if (opcode_i[5]) begin
      op_o.cnt = cnt_reg_i;
    end else if (imm == '0) begin
      op_o.cnt = CNT_W'(8);
    end else begin
      op_o.cnt = {{(CNT_W-IMM_W){1'b0}}, imm};
    end
  end
endmodule

// File: rtl/shift_lanes.sv
module shift_lanes
  import shift_cc_pkg::*;
(
  input  size_e             size_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [EXT_W-1:0]  op_z_o,
  output logic [EXT_W-1:0]  op_s_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [CNT_W-1:0]  width_o
);
  logic [EXT_W-1:0]  lane_z [LANES];
  logic [EXT_W-1:0]  lane_s [LANES];
  logic [DATA_W-1:0] lane_m [LANES];
  logic [CNT_W-1:0]  lane_w [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned LW = 8 << g;
    assign lane_z[g] = {{(EXT_W-LW){1'b0}}, dst_i[LW-1:0]};
    assign lane_s[g] = {{(EXT_W-LW){dst_i[LW-1]}}, dst_i[LW-1:0]};
    if (LW == DATA_W) begin : g_full
      assign lane_m[g] = '1;
    end else begin : g_part
      assign lane_m[g] = {{(DATA_W-LW){1'b0}}, {LW{1'b1}}};
    end
    assign lane_w[g] = CNT_W'(LW);
  end

  logic [1:0] idx;
  // memory form is always a word
  assign idx = (size_i == SZ_MEMW) ? 2'd1 : size_i;

  always_comb begin
    op_z_o  = lane_z[0];
    op_s_o  = lane_s[0];
    mask_o  = lane_m[0];
    width_o = lane_w[0];
    for (int i = 1; i < LANES; i++) begin
      if (idx == 2'(i)) begin
        op_z_o  = lane_z[i];
        op_s_o  = lane_s[i];
        mask_o  = lane_m[i];
        width_o = lane_w[i];
      end
    end
  end
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_cc_pkg::*;
(
  input  shift_op_t        op_i,
  input  logic [EXT_W-1:0] op_z_i,
  input  logic [EXT_W-1:0] op_s_i,
  input  logic [CNT_W-1:0] width_i,
  output logic [EXT_W-1:0] res_o,
  output logic             carry_o
);
  logic [EXT_W-1:0] shl, src;

  assign shl = op_z_i << op_i.cnt;
  assign src = op_i.logical ? op_z_i : op_s_i;

  always_comb begin
    if (op_i.left) begin
      res_o   = shl;
      // zero-extended operand: bit at width is 0 for count 0 or count past width
      carry_o = shl[width_i];
    end else begin
      if (op_i.logical) res_o = op_z_i >> op_i.cnt;
      else              res_o = EXT_W'($signed(op_s_i) >>> op_i.cnt);
      carry_o = (op_i.cnt == '0) ? 1'b0 : src[op_i.cnt - CNT_W'(1)];
    end
  end
endmodule

// File: rtl/shift_ovf.sv
module shift_ovf
  import shift_cc_pkg::*;
(
  input  logic             en_i,
  input  logic [EXT_W-1:0] op_s_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             ovf_o
);
  logic [CNT_W-1:0] amt;
  logic [EXT_W-1:0] shf, hi_mask, diff;

  // beyond the long width every sign bit has already been compared
  assign amt     = (cnt_i > CNT_W'(OVF_CAP)) ? CNT_W'(OVF_CAP) : cnt_i;
  assign shf     = op_s_i << amt;
  assign hi_mask = ~((EXT_W'(1) << (width_i - CNT_W'(1))) - EXT_W'(1));
  assign diff    = (shf ^ op_s_i) & hi_mask;
  assign ovf_o   = en_i & (|diff);
endmodule

// File: rtl/shift_cc_unit.sv
module shift_cc_unit
  import shift_cc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [15:0]       opcode_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] cnt_reg_i,
  input  logic              x_i,
  input  logic              ovf_full_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  shift_op_t         op;
  logic [EXT_W-1:0]  op_z, op_s, res;
  logic [DATA_W-1:0] mask, merged;
  logic [CNT_W-1:0]  width;
  logic              carry, ovf;
  logic [FLAG_W-1:0] flags_d;

  shift_decode u_dec (
    .opcode_i (opcode_i),
    .cnt_reg_i(cnt_reg_i[CNT_W-1:0]),
    .op_o     (op)
  );

  shift_lanes u_lanes (
    .size_i (op.size),
    .dst_i  (dst_i),
    .op_z_o (op_z),
    .op_s_o (op_s),
    .mask_o (mask),
    .width_o(width)
  );

  shift_core u_core (
    .op_i   (op),
    .op_z_i (op_z),
    .op_s_i (op_s),
    .width_i(width),
    .res_o  (res),
    .carry_o(carry)
  );

  shift_ovf u_ovf (
    .en_i   (ovf_full_i & op.left & ~op.logical),
    .op_s_i (op_s),
    .cnt_i  (op.cnt),
    .width_i(width),
    .ovf_o  (ovf)
  );

  assign merged = (dst_i & ~mask) | (res[DATA_W-1:0] & mask);

  always_comb begin
    flags_d        = '0;
    flags_d[FLG_C] = carry;
    flags_d[FLG_V] = ovf;
    flags_d[FLG_Z] = ((res[DATA_W-1:0] & mask) == '0);
    flags_d[FLG_N] = res[width - CNT_W'(1)];
    flags_d[FLG_X] = (op.cnt == '0) ? x_i : carry;
  end

  logic accept;
  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      flags_o     <= '0;
    end else if (accept) begin
      out_valid_o <= 1'b1;
      result_o    <= merged;
      flags_o     <= flags_d;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/shift_cc_chk.sv
module shift_cc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic [15:0] opcode_i,
  input logic [31:0] dst_i,
  input logic [31:0] cnt_reg_i,
  input logic        x_i,
  input logic        ovf_full_i,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] result_o,
  input logic [4:0]  flags_o
);
  logic acc;
  assign acc = in_valid_i & in_ready_o;

  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o);

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(result_o) && $stable(flags_o)));

  assert_byte_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && opcode_i[7:6] == 2'b00) |=> (result_o[31:8] == $past(dst_i[31:8])));

  assert_x_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && opcode_i[7:6] != 2'b11 && opcode_i[5] && cnt_reg_i[5:0] == 6'd0)
      |=> (flags_o[4] == $past(x_i) && !flags_o[0]));

  assert_nz_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(flags_o[3] && flags_o[2]));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (!ovf_full_i || !opcode_i[8] || opcode_i[3])) |=> !flags_o[1]);
endmodule

bind shift_cc_unit shift_cc_chk u_chk (.*);

// File: tb/shift_cc_unit_tb.sv
`timescale 1ns/1ps
module shift_cc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [15:0] opcode_i = '0;
  logic [31:0] dst_i = '0;
  logic [31:0] cnt_reg_i = '0;
  logic        x_i = 1'b0;
  logic        ovf_full_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] result_o;
  logic [4:0]  flags_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shift_cc_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .opcode_i(opcode_i), .dst_i(dst_i), .cnt_reg_i(cnt_reg_i), .x_i(x_i),
    .ovf_full_i(ovf_full_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .result_o(result_o), .flags_o(flags_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h dst=%h cnt=%0d act=%h exp=%h",
               tag, opcode_i, dst_i, cnt_reg_i[5:0], act, exp);
    end
  endtask

  // Reference: step the shift one bit at a time (R2 decode, R3 counts)
  task automatic model(output logic [31:0] res, output logic [4:0] fl);
    int w, n;
    logic [31:0] m, cur;
    logic sgn, c, v, arith, left;
    case (opcode_i[7:6])
      2'b00: w = 8;
      2'b10: w = 32;
      default: w = 16;
    endcase
    if (opcode_i[7:6] == 2'b11) n = 1;
    else if (opcode_i[5]) n = int'(cnt_reg_i[5:0]);
    else n = (opcode_i[11:9] == 0) ? 8 : int'(opcode_i[11:9]);
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    cur = dst_i & m;
    sgn = cur[w-1];
    left = opcode_i[8];
    arith = ~opcode_i[3];
    c = 1'b0; v = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (left) begin
        c = cur[w-1];
        cur = (cur << 1) & m;
        if (cur[w-1] != sgn) v = 1'b1;
      end else begin
        c = cur[0];
        cur = cur >> 1;
        if (arith && sgn) cur[w-1] = 1'b1;
      end
    end
    if (!(left && arith && ovf_full_i)) v = 1'b0;
    res = (dst_i & ~m) | cur;
    fl = {(n == 0) ? x_i : c, cur[w-1], cur == 0, v, c};
  endtask

  task automatic run_one(input logic [15:0] opc, input logic [31:0] d,
                         input logic [31:0] cr, input logic xi, input logic md);
    logic [31:0] er;
    logic [4:0] ef;
    opcode_i = opc; dst_i = d; cnt_reg_i = cr; x_i = xi; ovf_full_i = md;
    in_valid_i = 1'b1;
    model(er, ef);
    @(posedge clk);
    @(negedge clk);
    check("R1 valid", 32'(out_valid_o), 32'd1);
    if (opc[7:6] == 2'b11) check("R11 result", result_o, er);
    else check("R4 result", result_o & 32'h0000_00FF, er & 32'h0000_00FF);
    check("R5 upper/merge", result_o, er);
    check("R6 C", 32'(flags_o[0]), 32'(ef[0]));
    check("R7 X", 32'(flags_o[4]), 32'(ef[4]));
    check("R8 N", 32'(flags_o[3]), 32'(ef[3]));
    check("R8 Z", 32'(flags_o[2]), 32'(ef[2]));
    if (opc[7:6] == 2'b11) check("R11 V", 32'(flags_o[1]), 32'(ef[1]));
    else if (md && opc[8] && !opc[3]) check("R10 V", 32'(flags_o[1]), 32'(ef[1]));
    else check("R9 V", 32'(flags_o[1]), 32'(ef[1]));
  endtask

  logic [31:0] pats [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001,
                            32'hA5C3_8180, 32'h1234_4000, 32'h0000_00C0, 32'h5A5A_7F3F};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", 32'(out_valid_o), 32'd0);
    check("R1 reset ready", 32'(in_ready_o), 32'd1);
    rst_ni = 1'b1;
    @(negedge clk);

    // register-count sweep, counts 0..63 (R3 modulo 64, R6/R7 count zero)
    for (int sz = 0; sz < 3; sz++)
      for (int dir = 0; dir < 2; dir++)
        for (int lg = 0; lg < 2; lg++)
          for (int md = 0; md < 2; md++)
            for (int p = 0; p < 8; p++)
              for (int c = 0; c < 64; c++) begin
                logic [15:0] opc;
                opc = 16'hE020 | (16'(sz) << 6) | (16'(dir) << 8) | (16'(lg) << 3) | 16'(p % 8);
                // upper count bits set to prove only [5:0] is used
                run_one(opc, pats[p], 32'(c) | 32'hFFC0_0040 & 32'hFFFF_FFC0, p[0], md[0]);
              end

    // immediate-count sweep, field 0 means 8 (R3)
    for (int sz = 0; sz < 3; sz++)
      for (int dir = 0; dir < 2; dir++)
        for (int lg = 0; lg < 2; lg++)
          for (int md = 0; md < 2; md++)
            for (int p = 0; p < 8; p++)
              for (int f = 0; f < 8; f++) begin
                logic [15:0] opc;
                opc = 16'hE000 | (16'(f) << 9) | (16'(sz) << 6) | (16'(dir) << 8) | (16'(lg) << 3);
                run_one(opc, pats[p], 32'd0, ~p[0], md[0]);
              end

    // memory-word form (R11)
    for (int dir = 0; dir < 2; dir++)
      for (int lg = 0; lg < 2; lg++)
        for (int md = 0; md < 2; md++)
          for (int p = 0; p < 8; p++)
            run_one(16'hE0C0 | (16'(dir) << 8) | (16'(lg) << 3), pats[p], 32'd0, 1'b0, md[0]);

    // R1 backpressure: output held while consumer stalls
    in_valid_i = 1'b0;
    @(negedge clk);
    out_ready_i = 1'b0;
    run_one(16'hE180, 32'h4000_0001, 32'd0, 1'b0, 1'b1);
    in_valid_i = 1'b0;
    begin
      logic [31:0] r0;
      logic [4:0] f0;
      r0 = result_o; f0 = flags_o;
      repeat (3) @(negedge clk);
      check("R1 stall valid", 32'(out_valid_o), 32'd1);
      check("R1 stall ready", 32'(in_ready_o), 32'd0);
      check("R1 stall result", result_o, r0);
      check("R1 stall flags", 32'(flags_o), 32'(f0));
    end
    out_ready_i = 1'b1;
    @(negedge clk);
    check("R1 drain", 32'(out_valid_o), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule